// File: doc/BRIEF.md
# Per-Domain Fire Winner Arbiter

This block sits next to a 16-tile array. It runs once after each read phase. For every tile it takes the lock bit from before the phase and the lock bit from after it. A tile whose lock went from 0 to 1 counts as having fired. Each tile belongs to one of 16 domains, set by a 4-bit domain field. Within each domain the block picks one winning tile by priority. It flags a collision in any domain where more than one tile fired. It also builds an auto-reset domain mask by ORing the reset masks of all the winners.

Reset application is a separate step. A manual strobe clears every tile whose domain bit is set in a supplied mask. An auto strobe applies the stored auto-reset mask, but spares each winner and every tile on its parent chain. The result is a one-cycle per-tile clear vector. The tile array uses it to zero its threshold accumulator and its lock bit. The threshold arithmetic itself stays outside this block.

Top module: `domain_fire_arbiter`

## Requirements
- R1: Tile t fires when `lock_before_i[t]`=0 and `lock_after_i[t]`=1. Bit d of `fired_dom_o` is 1 exactly when at least one tile whose domain field `tile_dom_i[4t+3:4t]` equals d fired. Tiles that were already locked, or that stayed unlocked, never count.
- R2: `win_id_o[4d+3:4d]` holds the index of the fired tile in domain d that has the largest priority `tile_prio_i[8t+7:8t]`. Among tiles with equal priority, the lowest index wins. The field is 0 for a domain with no fired tile.
- R3: `coll_dom_o[d]` is 1 exactly when two or more tiles of domain d fired. `coll_any_o` is the OR of all collision bits.
- R4: `auto_mask_o` is the bitwise OR of `tile_rmask_i[16w+15:16w]` over the winner w of every domain that has a fired tile. It is 0 when nothing fired.
- R5: All arbitration results update on the rising edge where `sample_i`=1 and then hold until the next such edge. `res_valid_o` is high for exactly the one cycle after each sampling edge.
- R6: A manual apply works as follows. When `apply_man_i`=1 at an edge, `tile_clear_o[t]` is 1 in the following cycle exactly when `man_mask_i[dom(t)]`=1. No tile is exempt. When neither apply strobe is high, `tile_clear_o` is 0.
- R7: An auto apply works as follows. When `apply_auto_i`=1 at an edge, `tile_clear_o[t]` is 1 in the following cycle exactly when `auto_mask_o[dom(t)]`=1 and tile t is neither a winner nor an ancestor of a winner. Ancestors are found by following `tile_parent_i[4t+3:4t]` while `parent_vld_i` of the current tile is 1, for at most 15 steps. The parent chain is taken as it stood at the sampling edge. The domain table is taken at the apply edge.
- R8: While `rst` is high, all outputs go to 0 at each clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 1 | Capture arbitration for this phase |
| lock_before_i | input | 16 | Lock bits before the phase |
| lock_after_i | input | 16 | Lock bits after the phase |
| tile_dom_i | input | 64 | 4-bit domain per tile |
| tile_prio_i | input | 128 | 8-bit priority per tile |
| tile_rmask_i | input | 256 | 16-bit reset-on-fire domain mask per tile |
| tile_parent_i | input | 64 | 4-bit parent index per tile |
| parent_vld_i | input | 16 | Parent link valid per tile |
| apply_auto_i | input | 1 | Apply stored auto-reset mask with exemptions |
| apply_man_i | input | 1 | Apply manual domain mask |
| man_mask_i | input | 16 | Manual reset domain mask |
| res_valid_o | output | 1 | Arbitration results just updated |
| fired_dom_o | output | 16 | Domains with at least one fire |
| coll_dom_o | output | 16 | Domains with two or more fires |
| coll_any_o | output | 1 | Any domain collided |
| win_id_o | output | 64 | 4-bit winner index per domain |
| auto_mask_o | output | 16 | Auto-reset domain mask |
| tile_clear_o | output | 16 | One-cycle per-tile clear of threshold and lock |

## Verification
The arbitration outputs change one edge after `sample_i`, so the bench drives `sample_i` at a falling edge and compares them at the next falling edge. One cycle later it checks that `res_valid_o` has dropped and that the results have held. The clear vector is likewise due one edge after an apply strobe. The bench checks it at the falling edge that follows, then checks one cycle later that it has returned to zero. The expected winners, collisions, masks and exempt sets come from bench functions that are computed at the moment of sampling, using the tables that were driven.

// File: rtl/dfa_pkg.sv
package dfa_pkg;
  localparam int unsigned DFA_TILES_DEF = 16;
  localparam int unsigned DFA_DOM_W_DEF = 4;
  localparam int unsigned DFA_PRIO_W_DEF = 8;
endpackage

// File: rtl/dfa_fire_arb.sv
module dfa_fire_arb #(
  parameter int unsigned N_TILES = 16,
  parameter int unsigned DOM_W   = 4,
  parameter int unsigned PRIO_W  = 8,
  localparam int unsigned N_DOM  = 1 << DOM_W,
  localparam int unsigned ID_W   = $clog2(N_TILES)
) (
  input  logic [N_TILES-1:0]        fire_i,
  input  logic [N_TILES*DOM_W-1:0]  dom_i,
  input  logic [N_TILES*PRIO_W-1:0] prio_i,
  output logic [N_DOM-1:0]          any_o,
  output logic [N_DOM-1:0]          coll_o,
  output logic [N_DOM*ID_W-1:0]     win_o
);
  for (genvar d = 0; d < N_DOM; d++) begin : g_dom
    logic              found;
    logic              multi;
    logic [PRIO_W-1:0] best;
    logic [ID_W-1:0]   bid;
    // ascending scan with strict compare keeps the lowest index on a tie
    always_comb begin
      found = 1'b0;
      multi = 1'b0;
      best  = '0;
      bid   = '0;
      for (int t = 0; t < N_TILES; t++) begin
        if (fire_i[t] && dom_i[t*DOM_W +: DOM_W] == DOM_W'(d)) begin
          if (found) multi = 1'b1;
          if (!found || prio_i[t*PRIO_W +: PRIO_W] > best) begin
            best = prio_i[t*PRIO_W +: PRIO_W];
            bid  = ID_W'(t);
          end
          found = 1'b1;
        end
      end
    end
    assign any_o[d]                = found;
    assign coll_o[d]               = multi;
    assign win_o[d*ID_W +: ID_W]   = bid;
  end
endmodule

// File: rtl/dfa_ancestry.sv
module dfa_ancestry #(
  parameter int unsigned N_TILES = 16,
  localparam int unsigned ID_W   = $clog2(N_TILES)
) (
  input  logic [N_TILES*ID_W-1:0]    parent_i,
  input  logic [N_TILES-1:0]         pvld_i,
  output logic [N_TILES*N_TILES-1:0] anc_o
);
  for (genvar t = 0; t < N_TILES; t++) begin : g_tile
    logic [ID_W-1:0]    cur;
    logic               live;
    logic [N_TILES-1:0] acc;
    always_comb begin
      cur  = ID_W'(t);
      live = 1'b1;
      acc  = '0;
      for (int l = 0; l < N_TILES - 1; l++) begin
        if (live && pvld_i[cur]) begin
          cur      = parent_i[cur*ID_W +: ID_W];
          acc[cur] = 1'b1;
        end else begin
          live = 1'b0;
        end
      end
    end
    assign anc_o[t*N_TILES +: N_TILES] = acc;
  end
endmodule

// File: rtl/dfa_reset_plan.sv
module dfa_reset_plan #(
  parameter int unsigned N_TILES = 16,
  parameter int unsigned DOM_W   = 4,
  localparam int unsigned N_DOM  = 1 << DOM_W,
  localparam int unsigned ID_W   = $clog2(N_TILES)
) (
  input  logic [N_DOM-1:0]           any_i,
  input  logic [N_DOM*ID_W-1:0]      win_i,
  input  logic [N_TILES*N_DOM-1:0]   rmask_i,
  input  logic [N_TILES*N_TILES-1:0] anc_i,
  output logic [N_DOM-1:0]           auto_o,
  output logic [N_TILES-1:0]         exempt_o
);
  always_comb begin
    auto_o   = '0;
    exempt_o = '0;
    for (int d = 0; d < N_DOM; d++) begin
      if (any_i[d]) begin
        auto_o   = auto_o | rmask_i[win_i[d*ID_W +: ID_W]*N_DOM +: N_DOM];
        exempt_o = exempt_o | anc_i[win_i[d*ID_W +: ID_W]*N_TILES +: N_TILES];
        exempt_o[win_i[d*ID_W +: ID_W]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dfa_clear.sv
module dfa_clear #(
  parameter int unsigned N_TILES = 16,
  parameter int unsigned DOM_W   = 4,
  localparam int unsigned N_DOM  = 1 << DOM_W
) (
  input  logic [N_TILES*DOM_W-1:0] dom_i,
  input  logic                     man_en_i,
  input  logic [N_DOM-1:0]         man_mask_i,
  input  logic                     auto_en_i,
  input  logic [N_DOM-1:0]         auto_mask_i,
  input  logic [N_TILES-1:0]       exempt_i,
  output logic [N_TILES-1:0]       clear_o
);
  for (genvar t = 0; t < N_TILES; t++) begin : g_tile
    logic [DOM_W-1:0] dm;
    assign dm = dom_i[t*DOM_W +: DOM_W];
    assign clear_o[t] = (man_en_i && man_mask_i[dm]) ||
                        (auto_en_i && auto_mask_i[dm] && !exempt_i[t]);
  end
endmodule

// File: rtl/domain_fire_arbiter.sv
module domain_fire_arbiter #(
  parameter int unsigned N_TILES = dfa_pkg::DFA_TILES_DEF,
  parameter int unsigned DOM_W   = dfa_pkg::DFA_DOM_W_DEF,
  parameter int unsigned PRIO_W  = dfa_pkg::DFA_PRIO_W_DEF,
  localparam int unsigned N_DOM  = 1 << DOM_W,
  localparam int unsigned ID_W   = $clog2(N_TILES)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      sample_i,
  input  logic [N_TILES-1:0]        lock_before_i,
  input  logic [N_TILES-1:0]        lock_after_i,
  input  logic [N_TILES*DOM_W-1:0]  tile_dom_i,
  input  logic [N_TILES*PRIO_W-1:0] tile_prio_i,
  input  logic [N_TILES*N_DOM-1:0]  tile_rmask_i,
  input  logic [N_TILES*ID_W-1:0]   tile_parent_i,
  input  logic [N_TILES-1:0]        parent_vld_i,
  input  logic                      apply_auto_i,
  input  logic                      apply_man_i,
  input  logic [N_DOM-1:0]          man_mask_i,
  output logic                      res_valid_o,
  output logic [N_DOM-1:0]          fired_dom_o,
  output logic [N_DOM-1:0]          coll_dom_o,
  output logic                      coll_any_o,
  output logic [N_DOM*ID_W-1:0]     win_id_o,
  output logic [N_DOM-1:0]          auto_mask_o,
  output logic [N_TILES-1:0]        tile_clear_o
);
  logic [N_TILES-1:0]         fire;
  logic [N_DOM-1:0]           any_c, coll_c, auto_c;
  logic [N_DOM*ID_W-1:0]      win_c;
  logic [N_TILES*N_TILES-1:0] anc_c;
  logic [N_TILES-1:0]         exempt_c, exempt_q, clear_c;

  assign fire = lock_after_i & ~lock_before_i;

  dfa_fire_arb #(.N_TILES(N_TILES), .DOM_W(DOM_W), .PRIO_W(PRIO_W)) u_arb (
    .fire_i(fire), .dom_i(tile_dom_i), .prio_i(tile_prio_i),
    .any_o(any_c), .coll_o(coll_c), .win_o(win_c)
  );

  dfa_ancestry #(.N_TILES(N_TILES)) u_anc (
    .parent_i(tile_parent_i), .pvld_i(parent_vld_i), .anc_o(anc_c)
  );

  dfa_reset_plan #(.N_TILES(N_TILES), .DOM_W(DOM_W)) u_plan (
    .any_i(any_c), .win_i(win_c), .rmask_i(tile_rmask_i), .anc_i(anc_c),
    .auto_o(auto_c), .exempt_o(exempt_c)
  );

  dfa_clear #(.N_TILES(N_TILES), .DOM_W(DOM_W)) u_clr (
    .dom_i(tile_dom_i), .man_en_i(apply_man_i), .man_mask_i(man_mask_i),
    .auto_en_i(apply_auto_i), .auto_mask_i(auto_mask_o), .exempt_i(exempt_q),
    .clear_o(clear_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid_o  <= 1'b0;
      fired_dom_o  <= '0;
      coll_dom_o   <= '0;
      coll_any_o   <= 1'b0;
      win_id_o     <= '0;
      auto_mask_o  <= '0;
      exempt_q     <= '0;
      tile_clear_o <= '0;
    end else begin
      res_valid_o  <= sample_i;
      tile_clear_o <= clear_c;
      if (sample_i) begin
        fired_dom_o <= any_c;
        coll_dom_o  <= coll_c;
        coll_any_o  <= |coll_c;
        win_id_o    <= win_c;
        auto_mask_o <= auto_c;
        exempt_q    <= exempt_c;
      end
    end
  end
endmodule

// File: rtl/dfa_checker.sv
module dfa_checker #(
  parameter int unsigned N_TILES = 16,
  parameter int unsigned DOM_W   = 4,
  parameter int unsigned PRIO_W  = 8,
  localparam int unsigned N_DOM  = 1 << DOM_W,
  localparam int unsigned ID_W   = $clog2(N_TILES)
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      sample_i,
  input logic [N_TILES-1:0]        lock_before_i,
  input logic [N_TILES-1:0]        lock_after_i,
  input logic                      apply_auto_i,
  input logic                      apply_man_i,
  input logic [N_DOM-1:0]          man_mask_i,
  input logic                      res_valid_o,
  input logic [N_DOM-1:0]          fired_dom_o,
  input logic [N_DOM-1:0]          coll_dom_o,
  input logic                      coll_any_o,
  input logic [N_DOM*ID_W-1:0]     win_id_o,
  input logic [N_DOM-1:0]          auto_mask_o,
  input logic [N_TILES-1:0]        tile_clear_o
);
  AST_NO_FIRE_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
    $past(sample_i && ((lock_after_i & ~lock_before_i) == '0)) |->
      (fired_dom_o == '0 && auto_mask_o == '0 && win_id_o == '0)); // R1

  AST_COLL_NEEDS_FIRE: assert property (@(posedge clk) disable iff (rst)
    (coll_dom_o & ~fired_dom_o) == '0); // R3

  AST_COLL_ANY_MATCH: assert property (@(posedge clk) disable iff (rst)
    coll_any_o == (coll_dom_o != '0)); // R3

  AST_RESULTS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$past(sample_i) |-> ($stable(fired_dom_o) && $stable(win_id_o) &&
                          $stable(auto_mask_o) && !res_valid_o)); // R5

  AST_CLEAR_NEEDS_APPLY: assert property (@(posedge clk) disable iff (rst)
    (tile_clear_o != '0) |-> $past(apply_auto_i || apply_man_i)); // R6

  AST_MAN_ALL_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $past(apply_man_i && (&man_mask_i)) |-> (&tile_clear_o)); // R6
endmodule

bind domain_fire_arbiter dfa_checker #(
  .N_TILES(N_TILES), .DOM_W(DOM_W), .PRIO_W(PRIO_W)
) u_dfa_chk (.*);

// File: tb/test_domain_fire_arbiter.sv
module test_domain_fire_arbiter;
  localparam int N = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sample_i = 1'b0;
  logic [15:0]   lock_before_i = '0, lock_after_i = '0;
  logic [63:0]   tile_dom_i = '0;
  logic [127:0]  tile_prio_i = '0;
  logic [255:0]  tile_rmask_i = '0;
  logic [63:0]   tile_parent_i = '0;
  logic [15:0]   parent_vld_i = '0;
  logic          apply_auto_i = 1'b0, apply_man_i = 1'b0;
  logic [15:0]   man_mask_i = '0;
  logic          res_valid_o, coll_any_o;
  logic [15:0]   fired_dom_o, coll_dom_o, auto_mask_o, tile_clear_o;
  logic [63:0]   win_id_o;

  domain_fire_arbiter i_domain_fire_arbiter (.*);

  always #5ns clk = ~clk;

  int n_tests = 0, n_fail = 0;

  logic [3:0]  dom [N];
  logic [7:0]  prio [N];
  logic [15:0] rm [N];
  logic [3:0]  par [N];
  logic [15:0] pv, lb, la;
  // model results
  logic [15:0] m_fired, m_coll, m_auto, m_exempt;
  logic [63:0] m_win;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive_tables();
    for (int t = 0; t < N; t++) begin
      tile_dom_i[4*t +: 4]     = dom[t];
      tile_prio_i[8*t +: 8]    = prio[t];
      tile_rmask_i[16*t +: 16] = rm[t];
      tile_parent_i[4*t +: 4]  = par[t];
    end
    parent_vld_i  = pv;
    lock_before_i = lb;
    lock_after_i  = la;
  endtask

  function automatic logic [15:0] ancestors(input int t);
    logic [15:0] a = '0;
    int cur = t;
    for (int l = 0; l < N - 1; l++) begin
      if (!pv[cur]) break;
      cur = int'(par[cur]);
      a[cur] = 1'b1;
    end
    return a;
  endfunction

  task automatic model();
    m_fired = '0; m_coll = '0; m_auto = '0; m_exempt = '0; m_win = '0;
    for (int d = 0; d < 16; d++) begin
      int cnt = 0;
      int w = 0;
      for (int t = 0; t < N; t++) begin
        if (!lb[t] && la[t] && int'(dom[t]) == d) begin
          if (cnt == 0 || prio[t] > prio[w]) w = t;
          cnt++;
        end
      end
      if (cnt > 0) begin
        m_fired[d] = 1'b1;
        m_win[4*d +: 4] = 4'(w);
        m_auto |= rm[w];
        m_exempt |= ancestors(w);
        m_exempt[w] = 1'b1;
      end
      if (cnt > 1) m_coll[d] = 1'b1;
    end
  endtask

  // entered at a falling edge, returns at a falling edge
  task automatic do_sample();
    drive_tables();
    model();
    sample_i = 1'b1;
    @(negedge clk);
    sample_i = 1'b0;
    chk("R1 fired", 64'(fired_dom_o), 64'(m_fired));
    chk("R2 winner", win_id_o, m_win);
    chk("R3 coll", 64'(coll_dom_o), 64'(m_coll));
    chk("R3 coll_any", 64'(coll_any_o), 64'(m_coll != 0));
    chk("R4 auto mask", 64'(auto_mask_o), 64'(m_auto));
    chk("R5 valid pulse", 64'(res_valid_o), 64'd1);
    @(negedge clk);
    chk("R5 valid drop", 64'(res_valid_o), 64'd0);
    chk("R5 hold", 64'(fired_dom_o), 64'(m_fired));
  endtask

  task automatic do_auto();
    logic [15:0] e = '0;
    for (int t = 0; t < N; t++) e[t] = m_auto[dom[t]] && !m_exempt[t];
    apply_auto_i = 1'b1;
    @(negedge clk);
    apply_auto_i = 1'b0;
    chk("R7 auto clear", 64'(tile_clear_o), 64'(e));
    @(negedge clk);
    chk("R6 clear idle", 64'(tile_clear_o), 64'd0);
  endtask

  task automatic do_man(input logic [15:0] mk);
    logic [15:0] e = '0;
    for (int t = 0; t < N; t++) e[t] = mk[dom[t]];
    man_mask_i  = mk;
    apply_man_i = 1'b1;
    @(negedge clk);
    apply_man_i = 1'b0;
    chk("R6 manual clear", 64'(tile_clear_o), 64'(e));
    @(negedge clk);
    chk("R6 clear idle", 64'(tile_clear_o), 64'd0);
  endtask

  task automatic rand_tables(input int dmod);
    for (int t = 0; t < N; t++) begin
      dom[t]  = 4'($urandom % dmod);
      prio[t] = 8'($urandom % 4);
      rm[t]   = 16'($urandom);
      par[t]  = 4'($urandom);
    end
    pv = 16'($urandom);
    lb = 16'($urandom);
    la = 16'($urandom);
  endtask

  initial begin
    #2_000_000ns;
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R8 reset valid", 64'(res_valid_o), 64'd0);
    chk("R8 reset outputs", 64'(fired_dom_o | coll_dom_o | auto_mask_o | tile_clear_o), 64'd0);
    chk("R8 reset win", win_id_o, 64'd0);

    // directed: nothing fires (already locked / stays unlocked)
    for (int t = 0; t < N; t++) begin dom[t] = 4'(t); prio[t] = 8'd1; rm[t] = 16'hFFFF; par[t] = '0; end
    pv = '0; lb = 16'h00FF; la = 16'h00FF;
    do_sample();
    chk("R1 no fire auto", 64'(auto_mask_o), 64'd0);

    // directed: tie in domain 5 between tiles 3 and 9, winner 3 with collision
    for (int t = 0; t < N; t++) begin dom[t] = 4'd1; prio[t] = 8'd0; rm[t] = '0; end
    dom[3] = 4'd5; dom[9] = 4'd5; prio[3] = 8'd7; prio[9] = 8'd7;
    lb = '0; la = 16'h0208;
    do_sample();
    chk("R2 tie lowest id", 64'(win_id_o[23:20]), 64'd3);
    chk("R3 tie collides", 64'(coll_dom_o[5]), 64'd1);

    // directed: ancestor chain 2 -> 7 -> 12 spared from domain 0 auto reset
    for (int t = 0; t < N; t++) begin dom[t] = 4'd0; prio[t] = 8'd0; rm[t] = '0; par[t] = '0; end
    pv = '0; pv[2] = 1'b1; pv[7] = 1'b1; par[2] = 4'd7; par[7] = 4'd12;
    rm[2] = 16'h0001; lb = '0; la = 16'h0004;
    do_sample();
    do_auto();

    // random mix
    for (int i = 0; i < 400; i++) begin
      rand_tables((i % 3 == 0) ? 16 : 3);
      do_sample();
      if (i % 2 == 0) do_auto();
      else do_man(16'($urandom));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule